// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block sits beside the execution unit of a small 8-bit processor core and owns the interrupt handshake. It keeps one pending flag per request source. At an instruction boundary it decides whether a source can be taken. If one can, it runs a fixed eight-cycle entry: it clears the master enable, stores three bytes on a byte-wide stack, and finally hands the core a new program counter and stack pointer. Source 0 is the non-maskable source. Every other source is maskable and is gated by the master enable flag.

When the core decodes one of the two return commands, the sequencer runs a four-cycle exit. It reads the three stacked bytes back in reverse order and restores the program counter, the status word and the master enable bit. The non-maskable return also re-arms the non-maskable source. While either sequence runs, `busy_o` is high and the core must hold its own state updates. One clock is one machine cycle.

Top module: `irq_seq`

## Requirements
- R1: A pulse on `irq_i[i]` sets pending flag i, and the flag stays set across any number of cycles until it is accepted. A pulse on `clr_i[i]` or a reset drops the flag without any entry taking place.
- R2: Acceptance is only evaluated in a cycle where `insn_done_i` is high and no sequence is running. The entry then keeps `busy_o` high for exactly 8 cycles, and the PC and SP loads appear in the eighth of them.
- R3: Acceptance drives the master enable (`imf_o`) to 0 from the first entry cycle. While `imf_o` is 0, no maskable source (index 1 and above) is taken.
- R4: Only the accepted source's pending flag is cleared. Any other pending flag survives and can be taken at a later boundary.
- R5: The entry writes three bytes, one per cycle, at descending addresses starting at `sp_i`. The first byte is `psw_i` with bit 7 replaced by the pre-acceptance master enable. The second byte is `pc_i[15:8]` and the third is `pc_i[7:0]`. The SP is then loaded with `sp_i - 3`.
- R6: The PC is loaded with the 16-bit slice `vec_i[16*i +: 16]` of the accepted source i.
- R7: Source 0 is taken whatever the value of `imf_o`, and it beats every maskable source. Among maskable sources, the lowest pending index wins.
- R8: Once source 0 is accepted, further source-0 requests stay pending and are not taken until a non-maskable return (`retn_i`) completes. A maskable return (`reti_i`) leaves that block in place.
- R9: A return command reads addresses SP+1, SP+2 and SP+3 on three successive cycles. It then loads PC = {byte@SP+2, byte@SP+1}, loads PSW = byte@SP+3, sets `imf_o` to bit 7 of that byte, and loads SP+3. `busy_o` is high for 4 cycles.
- R10: An `imf_wr_i` pulse while idle sets `imf_o` to `imf_val_i` from the next cycle. The same pulse during a running sequence is ignored.
- R11: When a return command and `insn_done_i` arrive in the same idle cycle with a source eligible, the return runs and no entry starts in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Machine-cycle clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | NUM_SRC | Request pulses, one per source; bit 0 is non-maskable |
| clr_i | input | NUM_SRC | Software clear of pending flags |
| insn_done_i | input | 1 | Current instruction has completed |
| reti_i | input | 1 | Maskable return command |
| retn_i | input | 1 | Non-maskable return command |
| imf_wr_i | input | 1 | Write strobe for master enable |
| imf_val_i | input | 1 | Value for master enable write |
| pc_i | input | 16 | Current program counter (return address) |
| psw_i | input | 8 | Current status word |
| sp_i | input | SP_W | Current stack pointer |
| vec_i | input | NUM_SRC*16 | Entry addresses, 16 bits per source |
| mem_rdata_i | input | 8 | Stack read data, valid one cycle after `mem_re_o` |
| busy_o | output | 1 | Entry or return sequence in progress |
| imf_o | output | 1 | Master enable flag |
| mem_we_o | output | 1 | Stack write strobe |
| mem_re_o | output | 1 | Stack read strobe |
| mem_addr_o | output | SP_W | Stack address |
| mem_wdata_o | output | 8 | Stack write data |
| pc_ld_o | output | 1 | Load strobe for the core PC |
| pc_val_o | output | 16 | New PC value |
| psw_ld_o | output | 1 | Load strobe for the core PSW |
| psw_val_o | output | 8 | New PSW value |
| sp_ld_o | output | 1 | Load strobe for the core SP |
| sp_val_o | output | SP_W | New SP value |

## Verification
The bench looks for a stale master enable in the stored status byte. A design that saves the value after clearing it would return from every routine with interrupts off. It also issues a return together with a boundary strobe while a maskable source is eligible; a wrong arbitration there would start an entry on top of an exit and corrupt the stack. For source 0, the bench re-raises the request inside its own routine and again after a maskable return. A design that re-arms early would nest it. Other stimuli cover mid-sequence master-enable writes, pending flags that must survive another source's acceptance, and clears and resets that must leave nothing to accept.

// File: rtl/irq_seq_pkg.sv
`timescale 1ns/1ps
package irq_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ENTRY  = 2'd1,
        ST_RETURN = 2'd2
    } seq_state_e;

    // Fixed cycle budget of the entry and return walks.
    localparam int ENTRY_CYCLES = 8;
    localparam int RET_CYCLES   = 4;
    localparam int STACK_BYTES  = 3;

endpackage

// File: rtl/irq_seq_latch.sv
`timescale 1ns/1ps
module irq_seq_latch #(
    parameter int NUM_SRC = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_i,
    input  logic [NUM_SRC-1:0] clr_i,
    input  logic [NUM_SRC-1:0] ack_i,
    output logic [NUM_SRC-1:0] pend_o
);

    logic [NUM_SRC-1:0] pend_d;
    logic [NUM_SRC-1:0] pend_q;

    // A new request wins over a clear in the same cycle so none is lost.
    always_comb begin
        pend_d = (pend_q & ~clr_i & ~ack_i) | irq_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_d;
        end
    end

    assign pend_o = pend_q;

endmodule

// File: rtl/irq_seq_prio.sv
`timescale 1ns/1ps
module irq_seq_prio #(
    parameter int NUM_SRC = 4,
    parameter int SRC_W   = 2
) (
    input  logic [NUM_SRC-1:0] pend_i,
    input  logic               imf_i,
    input  logic               nmi_blk_i,
    output logic               vld_o,
    output logic [SRC_W-1:0]   idx_o
);

    logic [NUM_SRC-1:0] elig;

    // Source 0 ignores the master enable but honours its own in-service block.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_elig
        if (g == 0) begin : g_nmi
            assign elig[g] = pend_i[g] & ~nmi_blk_i;
        end else begin : g_mask
            assign elig[g] = pend_i[g] & imf_i;
        end
    end

    // Scan from the top so that the lowest eligible index is left standing.
    always_comb begin
        vld_o = |elig;
        idx_o = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (elig[i]) begin
                idx_o = SRC_W'(i);
            end
        end
    end

endmodule

// File: rtl/irq_seq.sv
`timescale 1ns/1ps
module irq_seq
    import irq_seq_pkg::*;
#(
    parameter int NUM_SRC = 4,
    parameter int BYTE_W  = 8,
    parameter int SP_W    = 8,
    parameter int IMF_BIT = 7
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_SRC-1:0]        irq_i,
    input  logic [NUM_SRC-1:0]        clr_i,
    input  logic                      insn_done_i,
    input  logic                      reti_i,
    input  logic                      retn_i,
    input  logic                      imf_wr_i,
    input  logic                      imf_val_i,
    input  logic [2*BYTE_W-1:0]       pc_i,
    input  logic [BYTE_W-1:0]         psw_i,
    input  logic [SP_W-1:0]           sp_i,
    input  logic [NUM_SRC*2*BYTE_W-1:0] vec_i,
    input  logic [BYTE_W-1:0]         mem_rdata_i,
    output logic                      busy_o,
    output logic                      imf_o,
    output logic                      mem_we_o,
    output logic                      mem_re_o,
    output logic [SP_W-1:0]           mem_addr_o,
    output logic [BYTE_W-1:0]         mem_wdata_o,
    output logic                      pc_ld_o,
    output logic [2*BYTE_W-1:0]       pc_val_o,
    output logic                      psw_ld_o,
    output logic [BYTE_W-1:0]         psw_val_o,
    output logic                      sp_ld_o,
    output logic [SP_W-1:0]           sp_val_o
);

    localparam int PC_W  = 2 * BYTE_W;
    localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam int CNT_W = $clog2(ENTRY_CYCLES);

    localparam logic [CNT_W-1:0] CNT_PUSHES   = CNT_W'(STACK_BYTES);
    localparam logic [CNT_W-1:0] CNT_ENT_LAST = CNT_W'(ENTRY_CYCLES - 1);
    localparam logic [CNT_W-1:0] CNT_RET_LAST = CNT_W'(RET_CYCLES - 1);
    localparam logic [CNT_W-1:0] CNT_LO_RDY   = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_HI_RDY   = CNT_W'(2);
    localparam logic [SRC_W-1:0] NMI_IDX      = '0;

    typedef struct packed {
        seq_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic              imf;
        logic              nmi_act;
        logic              ret_nmi;
        logic [SRC_W-1:0]  src;
        logic [PC_W-1:0]   pc;
        logic [BYTE_W-1:0] psw;
        logic [SP_W-1:0]   wp;
    } seq_t;

    seq_t seq_d;
    seq_t seq_q;

    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] ack_vec;
    logic               pick_vld;
    logic [SRC_W-1:0]   pick_idx;
    logic               ret_go;
    logic               acc_go;

    irq_seq_latch #(
        .NUM_SRC (NUM_SRC)
    ) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .irq_i  (irq_i),
        .clr_i  (clr_i),
        .ack_i  (ack_vec),
        .pend_o (pend)
    );

    irq_seq_prio #(
        .NUM_SRC (NUM_SRC),
        .SRC_W   (SRC_W)
    ) u_prio (
        .pend_i    (pend),
        .imf_i     (seq_q.imf),
        .nmi_blk_i (seq_q.nmi_act),
        .vld_o     (pick_vld),
        .idx_o     (pick_idx)
    );

    // Next-state computation for the whole sequencer.
    always_comb begin
        seq_d   = seq_q;
        ret_go  = 1'b0;
        acc_go  = 1'b0;
        ack_vec = '0;
        case (seq_q.st)
            ST_IDLE: begin
                ret_go = reti_i | retn_i;
                acc_go = !ret_go && insn_done_i && pick_vld;
                if (ret_go) begin
                    seq_d.st      = ST_RETURN;
                    seq_d.cnt     = '0;
                    seq_d.wp      = sp_i;
                    seq_d.ret_nmi = retn_i;
                end else if (acc_go) begin
                    ack_vec[pick_idx]    = 1'b1;
                    seq_d.st             = ST_ENTRY;
                    seq_d.cnt            = '0;
                    seq_d.imf            = 1'b0;
                    seq_d.src            = pick_idx;
                    seq_d.pc             = pc_i;
                    seq_d.psw            = psw_i;
                    seq_d.psw[IMF_BIT]   = seq_q.imf;
                    seq_d.wp             = sp_i;
                    if (pick_idx == NMI_IDX) begin
                        seq_d.nmi_act = 1'b1;
                    end
                end else if (imf_wr_i) begin
                    seq_d.imf = imf_val_i;
                end
            end
            ST_ENTRY: begin
                seq_d.cnt = seq_q.cnt + 1'b1;
                if (seq_q.cnt < CNT_PUSHES) begin
                    seq_d.wp = seq_q.wp - 1'b1;
                end
                if (seq_q.cnt == CNT_ENT_LAST) begin
                    seq_d.st  = ST_IDLE;
                    seq_d.cnt = '0;
                end
            end
            ST_RETURN: begin
                seq_d.cnt = seq_q.cnt + 1'b1;
                if (seq_q.cnt < CNT_PUSHES) begin
                    seq_d.wp = seq_q.wp + 1'b1;
                end
                if (seq_q.cnt == CNT_LO_RDY) begin
                    seq_d.pc[BYTE_W-1:0] = mem_rdata_i;
                end
                if (seq_q.cnt == CNT_HI_RDY) begin
                    seq_d.pc[PC_W-1:BYTE_W] = mem_rdata_i;
                end
                if (seq_q.cnt == CNT_RET_LAST) begin
                    seq_d.st  = ST_IDLE;
                    seq_d.cnt = '0;
                    seq_d.imf = mem_rdata_i[IMF_BIT];
                    if (seq_q.ret_nmi) begin
                        seq_d.nmi_act = 1'b0;
                    end
                end
            end
            default: begin
                seq_d.st  = ST_IDLE;
                seq_d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    // Output decode from registered state only.
    always_comb begin
        mem_we_o    = 1'b0;
        mem_re_o    = 1'b0;
        mem_addr_o  = seq_q.wp;
        mem_wdata_o = '0;
        pc_ld_o     = 1'b0;
        pc_val_o    = seq_q.pc;
        psw_ld_o    = 1'b0;
        psw_val_o   = mem_rdata_i;
        sp_ld_o     = 1'b0;
        sp_val_o    = seq_q.wp;
        case (seq_q.st)
            ST_ENTRY: begin
                if (seq_q.cnt < CNT_PUSHES) begin
                    mem_we_o = 1'b1;
                    case (seq_q.cnt)
                        CNT_W'(0): mem_wdata_o = seq_q.psw;
                        CNT_W'(1): mem_wdata_o = seq_q.pc[PC_W-1:BYTE_W];
                        default:   mem_wdata_o = seq_q.pc[BYTE_W-1:0];
                    endcase
                end
                if (seq_q.cnt == CNT_ENT_LAST) begin
                    pc_ld_o  = 1'b1;
                    pc_val_o = vec_i[seq_q.src*PC_W +: PC_W];
                    sp_ld_o  = 1'b1;
                end
            end
            ST_RETURN: begin
                if (seq_q.cnt < CNT_PUSHES) begin
                    mem_re_o   = 1'b1;
                    mem_addr_o = seq_q.wp + 1'b1;
                end
                if (seq_q.cnt == CNT_RET_LAST) begin
                    pc_ld_o  = 1'b1;
                    psw_ld_o = 1'b1;
                    sp_ld_o  = 1'b1;
                end
            end
            default: begin
                mem_we_o = 1'b0;
            end
        endcase
    end

    assign busy_o = (seq_q.st != ST_IDLE);
    assign imf_o  = seq_q.imf;

endmodule

// File: rtl/irq_seq_chk.sv
`timescale 1ns/1ps
module irq_seq_chk #(
    parameter int SP_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy_o,
    input logic            imf_o,
    input logic            mem_we_o,
    input logic            mem_re_o,
    input logic [SP_W-1:0] mem_addr_o,
    input logic            push_imf,
    input logic            pc_ld_o,
    input logic            psw_ld_o,
    input logic            sp_ld_o,
    input logic [SP_W-1:0] sp_val_o
);

    AST_PORT_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we_o && mem_re_o)); // R5

    AST_IMF_LOW_ON_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_o) |-> !imf_o); // R3

    AST_SAVED_IMF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_o) |-> push_imf == $past(imf_o)); // R5

    AST_PUSH_DESCEND: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o && !$past(mem_we_o) |=> mem_we_o && mem_addr_o == SP_W'($past(mem_addr_o) - 1'b1)); // R5

    AST_ENTRY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        pc_ld_o && !psw_ld_o |-> $past(busy_o, 7) && !$past(busy_o, 8)); // R2

    AST_VECTOR_AFTER_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        pc_ld_o && !psw_ld_o |-> $past(mem_we_o, 5) && sp_ld_o); // R6

    AST_POP_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re_o && $past(mem_re_o) |-> mem_addr_o == SP_W'($past(mem_addr_o) + 1'b1)); // R9

    AST_RETURN_SP: assert property (@(posedge clk) disable iff (!rst_n)
        psw_ld_o |-> pc_ld_o && sp_ld_o && sp_val_o == $past(mem_addr_o)); // R9

    AST_LOAD_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_ld_o || psw_ld_o || sp_ld_o) |-> busy_o); // R2

endmodule

bind irq_seq irq_seq_chk #(
    .SP_W (SP_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy_o     (busy_o),
    .imf_o      (imf_o),
    .mem_we_o   (mem_we_o),
    .mem_re_o   (mem_re_o),
    .mem_addr_o (mem_addr_o),
    .push_imf   (mem_wdata_o[IMF_BIT]),
    .pc_ld_o    (pc_ld_o),
    .psw_ld_o   (psw_ld_o),
    .sp_ld_o    (sp_ld_o),
    .sp_val_o   (sp_val_o)
);

// File: tb/irq_seq_tb.sv
`timescale 1ns/1ps
module irq_seq_tb;

    localparam int N    = 4;
    localparam int SP_W = 8;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic              rst_n;
    logic [N-1:0]      irq_i, clr_i;
    logic              insn_done_i, reti_i, retn_i, imf_wr_i, imf_val_i;
    logic [15:0]       pc_i;
    logic [7:0]        psw_i;
    logic [SP_W-1:0]   sp_i;
    logic [N*16-1:0]   vec_i;
    logic [7:0]        mem_rdata_i;
    logic              busy_o, imf_o, mem_we_o, mem_re_o;
    logic [SP_W-1:0]   mem_addr_o;
    logic [7:0]        mem_wdata_o;
    logic              pc_ld_o, psw_ld_o, sp_ld_o;
    logic [15:0]       pc_val_o;
    logic [7:0]        psw_val_o;
    logic [SP_W-1:0]   sp_val_o;

    irq_seq #(.NUM_SRC(N), .SP_W(SP_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .clr_i(clr_i),
        .insn_done_i(insn_done_i), .reti_i(reti_i), .retn_i(retn_i),
        .imf_wr_i(imf_wr_i), .imf_val_i(imf_val_i), .pc_i(pc_i),
        .psw_i(psw_i), .sp_i(sp_i), .vec_i(vec_i), .mem_rdata_i(mem_rdata_i),
        .busy_o(busy_o), .imf_o(imf_o), .mem_we_o(mem_we_o), .mem_re_o(mem_re_o),
        .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .pc_ld_o(pc_ld_o),
        .pc_val_o(pc_val_o), .psw_ld_o(psw_ld_o), .psw_val_o(psw_val_o),
        .sp_ld_o(sp_ld_o), .sp_val_o(sp_val_o)
    );

    typedef enum int {EV_WR = 1, EV_RD = 2, EV_PC = 3, EV_PSW = 4, EV_SP = 5} ev_kind_e;
    typedef struct {
        ev_kind_e    k;
        int unsigned a;
        int unsigned v;
        string       req;
    } ev_t;

    ev_t           exq[$];
    int            total = 0;
    int            bad   = 0;
    logic [7:0]    mem     [0:255];
    logic [7:0]    exp_stk [0:255];
    logic [SP_W-1:0] sp_core;
    logic          imf_exp;

    assign sp_i = sp_core;

    function automatic logic [15:0] vec_of(int i);
        return 16'h8040 + 16'(i) * 16'h0100;
    endfunction

    // Stack memory model: write now, read data one cycle later.
    always @(posedge clk) begin
        if (mem_we_o) mem[mem_addr_o] <= mem_wdata_o;
        if (mem_re_o) mem_rdata_i <= mem[mem_addr_o];
    end

    task automatic chk(bit ok, string req, string what, int unsigned act, int unsigned exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic push_ev(ev_kind_e k, int unsigned a, int unsigned v, string req);
        ev_t e;
        e.k = k; e.a = a; e.v = v; e.req = req;
        exq.push_back(e);
    endtask

    task automatic pop_cmp(ev_kind_e k, int unsigned a, int unsigned v);
        ev_t e;
        int unsigned act;
        act = (int'(k) << 24) | (a << 16) | v;
        if (exq.size() == 0) begin
            chk(1'b0, "R2", "unexpected output event", act, 0);
        end else begin
            e = exq.pop_front();
            chk(e.k == k && e.a == a && e.v == v, e.req, "output event",
                act, (int'(e.k) << 24) | (e.a << 16) | e.v);
        end
    endtask

    // Monitor: compares every produced event with the scoreboard queue.
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_we_o) pop_cmp(EV_WR, mem_addr_o, mem_wdata_o);
            if (mem_re_o) pop_cmp(EV_RD, mem_addr_o, 0);
            if (pc_ld_o)  pop_cmp(EV_PC, 0, pc_val_o);
            if (psw_ld_o) pop_cmp(EV_PSW, 0, psw_val_o);
            if (sp_ld_o) begin
                pop_cmp(EV_SP, 0, sp_val_o);
                sp_core = sp_val_o;
            end
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_irq(logic [N-1:0] m);
        irq_i = m;
        @(negedge clk);
        irq_i = '0;
    endtask

    task automatic set_imf(bit v);
        imf_wr_i = 1'b1; imf_val_i = v;
        @(negedge clk);
        imf_wr_i = 1'b0;
        imf_exp = v;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy_o) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic try_none(string req);
        insn_done_i = 1'b1;
        @(negedge clk);
        insn_done_i = 1'b0;
        chk(!busy_o, req, "boundary must not start entry", busy_o, 0);
        @(negedge clk);
        chk(!busy_o && !mem_we_o, req, "still idle after boundary", busy_o, 0);
    endtask

    // Driver: queue the expected entry walk, then strobe the boundary.
    task automatic enter(int src, logic [15:0] pc, logic [7:0] ps, bit poke, string req);
        logic [7:0] a;
        logic [7:0] b0;
        int n;
        int pre;
        a  = sp_core;
        b0 = {imf_exp, ps[6:0]};
        exp_stk[a]        = b0;
        exp_stk[a - 8'd1] = pc[15:8];
        exp_stk[a - 8'd2] = pc[7:0];
        push_ev(EV_WR, a, b0, "R5");
        push_ev(EV_WR, a - 8'd1, pc[15:8], "R5");
        push_ev(EV_WR, a - 8'd2, pc[7:0], "R5");
        push_ev(EV_PC, 0, vec_of(src), req);
        push_ev(EV_SP, 0, a - 8'd3, "R5");
        pc_i = pc; psw_i = ps;
        insn_done_i = 1'b1;
        @(negedge clk);
        insn_done_i = 1'b0;
        chk(busy_o, "R2", "entry starts after boundary", busy_o, 1);
        chk(!imf_o, "R3", "master enable cleared on entry", imf_o, 0);
        pre = 0;
        if (poke) begin
            imf_wr_i = 1'b1; imf_val_i = 1'b1;
            @(negedge clk);
            imf_wr_i = 1'b0;
            pre = 1;
        end
        wait_idle(n);
        chk(n + pre == 8, "R2", "entry length", n + pre, 8);
        imf_exp = 1'b0;
        chk(imf_o == 1'b0, poke ? "R10" : "R3", "master enable after entry", imf_o, 0);
    endtask

    task automatic leave(bit nmi, bit with_done, string req);
        logic [7:0] a;
        logic [7:0] pcl, pch, ps;
        int n;
        a   = sp_core;
        pcl = exp_stk[a + 8'd1];
        pch = exp_stk[a + 8'd2];
        ps  = exp_stk[a + 8'd3];
        push_ev(EV_RD, a + 8'd1, 0, "R9");
        push_ev(EV_RD, a + 8'd2, 0, "R9");
        push_ev(EV_RD, a + 8'd3, 0, "R9");
        push_ev(EV_PC, 0, {pch, pcl}, "R9");
        push_ev(EV_PSW, 0, ps, "R9");
        push_ev(EV_SP, 0, a + 8'd3, "R9");
        reti_i = !nmi; retn_i = nmi; insn_done_i = with_done;
        @(negedge clk);
        reti_i = 1'b0; retn_i = 1'b0; insn_done_i = 1'b0;
        wait_idle(n);
        chk(n == 4, req, "return length", n, 4);
        chk(imf_o == ps[7], "R9", "master enable restored", imf_o, ps[7]);
        imf_exp = ps[7];
    endtask

    initial begin
        for (int i = 0; i < N; i++) vec_i[i*16 +: 16] = vec_of(i);
        for (int i = 0; i < 256; i++) begin
            mem[i] = 8'h00;
            exp_stk[i] = 8'h00;
        end
        rst_n = 1'b0; irq_i = '0; clr_i = '0; insn_done_i = 1'b0;
        reti_i = 1'b0; retn_i = 1'b0; imf_wr_i = 1'b0; imf_val_i = 1'b0;
        pc_i = '0; psw_i = '0; sp_core = 8'hF0; imf_exp = 1'b0;
        cyc(3);
        chk(!busy_o && !mem_we_o && !pc_ld_o, "R2", "idle in reset", busy_o, 0);
        chk(!imf_o, "R3", "master enable low in reset", imf_o, 0);
        rst_n = 1'b1;
        cyc(1);

        // Held request, masked until the enable is written.
        pulse_irq(4'b0100);
        cyc(3);
        try_none("R3");
        set_imf(1'b1);
        chk(imf_o, "R10", "master enable write", imf_o, 1);
        enter(2, 16'h1234, 8'h05, 1'b0, "R1");
        leave(1'b0, 1'b0, "R9");
        try_none("R4");

        // Two maskable sources: lowest first, the other survives.
        pulse_irq(4'b1010);
        enter(1, 16'hA5C3, 8'h21, 1'b0, "R7");
        set_imf(1'b1);
        leave(1'b0, 1'b1, "R11");
        enter(3, 16'h0F0E, 8'h33, 1'b0, "R4");
        leave(1'b0, 1'b0, "R9");

        // Non-maskable source with the enable off.
        set_imf(1'b0);
        pulse_irq(4'b0101);
        enter(0, 16'h4455, 8'h80, 1'b0, "R7");
        pulse_irq(4'b0001);
        try_none("R8");
        leave(1'b1, 1'b0, "R9");
        enter(0, 16'h6677, 8'h01, 1'b0, "R8");
        leave(1'b1, 1'b0, "R9");
        try_none("R3");
        pulse_irq(4'b0001);
        enter(0, 16'h2468, 8'h10, 1'b0, "R6");
        leave(1'b0, 1'b0, "R9");
        try_none("R8");

        // Reset drops every pending flag.
        rst_n = 1'b0;
        cyc(2);
        rst_n = 1'b1;
        imf_exp = 1'b0;
        cyc(1);
        set_imf(1'b1);
        try_none("R1");

        // Software clear drops a flag.
        pulse_irq(4'b1000);
        clr_i = 4'b1000;
        @(negedge clk);
        clr_i = '0;
        try_none("R1");

        // Enable write during entry is ignored.
        pulse_irq(4'b0010);
        enter(1, 16'h1357, 8'h44, 1'b1, "R6");
        leave(1'b0, 1'b0, "R9");

        cyc(4);
        chk(exq.size() == 0, "R2", "all expected events produced", exq.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R2 watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule